// File: doc/BRIEF.md
# Write-Protected Configuration EEPROM Slave (Two-Wire Serial)

This block is a two-wire serial slave that presents a 256-byte configuration memory to a bus master. The master selects it with a 7-bit device address made of the fixed type nibble 1010 followed by three strap inputs. It sends a word address to set an internal pointer, then either writes data bytes at that pointer or reads bytes from it. The pointer advances after every byte moved and wraps from 255 to 0, so a read with no address phase simply carries on where the last access stopped.

The bottom half of the memory, bytes 0 to 127, is fixed content computed in logic and can never be altered over the bus. The top half, bytes 128 to 255, is held in registers and accepts writes only while the protect input is low. Writes to a locked or protected location are still acknowledged but leave the memory unchanged. After the STOP that closes a transaction with at least one data byte, the slave models an internal programming time. For that window it refuses its own address.

The clock and data lines reach the block as plain inputs from an open-drain bus. The block pulls the data line low through an output-enable and never drives the clock. Both inputs are synchronised into the system clock and filtered, so short pulses on either line never reach the protocol logic.

Top module: `spd_eeprom_slave`

## Requirements
- R1: The slave acknowledges (drives data low on the ninth clock) only when the 7-bit address equals binary 1010 followed by strapAddr[2:0]. Any other address gets no acknowledge and the data line stays released.
- R2: A write transaction (address byte with R/W bit 0, then a word-address byte) loads the pointer. Each following data byte is stored at the pointer when the pointer is at 128 or above and wpIn is low. After storing, the pointer advances.
- R3: A data byte sent to a location from 0 to 127 is acknowledged and leaves that location unchanged.
- R4: While wpIn is high, a data byte sent to a location from 128 to 255 is acknowledged and leaves that location unchanged.
- R5: A read (R/W bit 1) returns the byte at the pointer MSB first and then advances the pointer. The master acknowledge continues the read; a master NACK ends it. The pointer wraps from 255 to 0. A read without an address phase continues from the current pointer.
- R6: Fixed content: byte i for i from 0 to 127 other than 63 is (5*i + 0x11) mod 256. Byte 63 is the sum of bytes 0 to 62 modulo 256.
- R7: After a STOP that ends a transaction containing at least one data byte, the slave withholds its acknowledge for WRITE_CYCLES system clocks. After that it acknowledges again.
- R8: A pulse on either line that lasts fewer than FILT_LEN system clocks has no effect on the protocol.
- R9: After reset the data line is released, the pointer is 0 and bytes 128 to 255 read 0xFF.
- R10: The slave changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sensed level of the bus clock line |
| sdaIn | input | 1 | Sensed level of the bus data line |
| sdaOe | output | 1 | When 1, pull the data line low |
| strapAddr | input | 3 | Low three bits of the device address |
| wpIn | input | 1 | Write protect for bytes 128 to 255, active high |

## Verification
The bench builds the slave with FILT_LEN of 4 and WRITE_CYCLES of 2000, with a bus quarter-bit of 10 system clocks. With these values an address probe issued right after a write STOP lands inside the programming window, and a probe issued after waiting falls outside it, so both sides of the busy window can be checked in a short run. A two-clock pulse on the clock line sits below the filter threshold, while real bus edges stay stable long enough to pass the filter well inside each quarter-bit.

// File: rtl/spd_eeprom_pkg.sv
`timescale 1ns/1ps
package spd_eeprom_pkg;

  localparam int ADDR_W = 8;
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int LOCKED_BYTES = MEM_BYTES / 2;
  localparam int SUM_INDEX = 63;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  function automatic logic [7:0] lockedPattern(input logic [ADDR_W-1:0] idx);
    logic [7:0] val;
    val = idx * 8'd5 + 8'h11;
    return val;
  endfunction

  function automatic logic [7:0] lockedChecksum();
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < SUM_INDEX; i++) begin
      acc = acc + lockedPattern(ADDR_W'(i));
    end
    return acc;
  endfunction

endpackage

// File: rtl/spd_line_filter.sv
`timescale 1ns/1ps
module spd_line_filter #(
  parameter int FILT_LEN = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic syncA;
  logic syncB;
  logic [CW-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= 1'b1;
      syncB     <= 1'b1;
      lineOut   <= 1'b1;
      stableCnt <= '0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      if (syncB == lineOut) begin
        stableCnt <= '0;
      end else if (stableCnt == CW'(FILT_LEN - 1)) begin
        lineOut   <= syncB;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_ctrl.sv
`timescale 1ns/1ps
module spd_eeprom_ctrl
  import spd_eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 3750000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [2:0] strapAddr,
  input  logic [7:0] rxByte,
  output dpStrobe_t  strobe,
  output ctrlState_t state,
  output logic       ackDrive,
  output logic       sendPhase,
  output logic       busy
);
  localparam int BW = $clog2(WRITE_CYCLES + 1);

  logic sclPrev, sdaPrev;
  logic startEv, stopEv, sclRise, sclFall;
  logic [3:0] bitCnt, nBit;
  logic rwBit, nRw;
  logic mAck, nMAck;
  logic wrPending, nWrPend;
  logic [BW-1:0] busyCnt, nBusyCnt;
  ctrlState_t nState;
  logic nAck, nSend;
  logic addrHit;

  assign startEv = sclF && sclPrev && sdaPrev && !sdaF;
  assign stopEv  = sclF && sclPrev && !sdaPrev && sdaF;
  assign sclRise = sclF && !sclPrev;
  assign sclFall = !sclF && sclPrev;
  assign busy    = (busyCnt != '0);
  assign addrHit = (rxByte[7:1] == {DEV_TYPE, strapAddr});

  always_comb begin
    nState   = state;
    nBit     = bitCnt;
    nRw      = rwBit;
    nMAck    = mAck;
    nAck     = ackDrive;
    nSend    = sendPhase;
    nWrPend  = wrPending;
    nBusyCnt = busy ? busyCnt - 1'b1 : busyCnt;
    strobe   = '0;
    if (startEv) begin
      nState = ST_DEV;
      nBit   = '0;
      nAck   = 1'b0;
      nSend  = 1'b0;
    end else if (stopEv) begin
      nState = ST_IDLE;
      nAck   = 1'b0;
      nSend  = 1'b0;
      if (wrPending) begin
        nBusyCnt = BW'(WRITE_CYCLES);
        nWrPend  = 1'b0;
      end
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            strobe.shiftIn = 1'b1;
            nBit = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nBit = '0;
            if (state == ST_DEV) begin
              if (addrHit && !busy) begin
                nAck   = 1'b1;
                nRw    = rxByte[0];
                nState = ST_DEV_ACK;
              end else begin
                nState = ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              nAck           = 1'b1;
              strobe.loadPtr = 1'b1;
              nState         = ST_WADDR_ACK;
            end else begin
              nAck            = 1'b1;
              strobe.writeMem = 1'b1;
              nWrPend         = 1'b1;
              nState          = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            nAck = 1'b0;
            if (rwBit) begin
              strobe.loadTx = 1'b1;
              nSend  = 1'b1;
              nState = ST_RDATA;
            end else begin
              nState = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            nAck   = 1'b0;
            nState = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            nBit = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              nBit   = '0;
              nSend  = 1'b0;
              nState = ST_RDATA_ACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclRise) begin
            nMAck = !sdaF;
          end else if (sclFall) begin
            if (mAck) begin
              strobe.loadTx = 1'b1;
              nSend  = 1'b1;
              nState = ST_RDATA;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwBit     <= 1'b0;
      mAck      <= 1'b0;
      ackDrive  <= 1'b0;
      sendPhase <= 1'b0;
      wrPending <= 1'b0;
      busyCnt   <= '0;
    end else begin
      sclPrev   <= sclF;
      sdaPrev   <= sdaF;
      state     <= nState;
      bitCnt    <= nBit;
      rwBit     <= nRw;
      mAck      <= nMAck;
      ackDrive  <= nAck;
      sendPhase <= nSend;
      wrPending <= nWrPend;
      busyCnt   <= nBusyCnt;
    end
  end
endmodule

// File: rtl/spd_eeprom_datapath.sv
`timescale 1ns/1ps
module spd_eeprom_datapath
  import spd_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic              wpIn,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              txMsb
);
  localparam int UPPER_W = ADDR_W - 1;
  localparam int UPPER_BYTES = MEM_BYTES - LOCKED_BYTES;
  localparam logic [7:0] SUM_BYTE = lockedChecksum();

  logic [7:0] upperMem [UPPER_BYTES];
  logic [7:0] txShift;
  logic [7:0] rdByte;
  logic [UPPER_W-1:0] upperIdx;
  logic inUpper;

  assign inUpper  = ptr[ADDR_W-1];
  assign upperIdx = ptr[UPPER_W-1:0];
  assign txMsb    = txShift[7];

  always_comb begin
    if (inUpper) begin
      rdByte = upperMem[upperIdx];
    end else if (ptr == ADDR_W'(SUM_INDEX)) begin
      rdByte = SUM_BYTE;
    end else begin
      rdByte = lockedPattern(ptr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      ptr     <= '0;
      txShift <= 8'hFF;
    end else begin
      if (strobe.shiftIn) begin
        rxByte <= {rxByte[6:0], sdaBit};
      end
      if (strobe.loadPtr) begin
        ptr <= rxByte;
      end else if (strobe.writeMem || strobe.loadTx) begin
        ptr <= ptr + 1'b1;
      end
      if (strobe.loadTx) begin
        txShift <= rdByte;
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  for (genvar g = 0; g < UPPER_BYTES; g++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upperMem[g] <= 8'hFF;
      end else if (strobe.writeMem && inUpper && !wpIn && upperIdx == UPPER_W'(g)) begin
        upperMem[g] <= rxByte;
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_slave.sv
`timescale 1ns/1ps
module spd_eeprom_slave
  import spd_eeprom_pkg::*;
#(
  parameter int FILT_LEN = 25,
  parameter int WRITE_CYCLES = 3750000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [2:0] strapAddr,
  input  logic       wpIn
);
  logic [1:0] rawLines;
  logic [1:0] cleanLines;
  logic sclFilt, sdaFilt;
  dpStrobe_t strobe;
  ctrlState_t ctrlState;
  logic ackDrive, sendPhase, busy, txMsb;
  logic [7:0] rxByte;
  logic [ADDR_W-1:0] ptr;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    spd_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (rawLines[g]),
      .lineOut (cleanLines[g])
    );
  end

  assign sclFilt = cleanLines[0];
  assign sdaFilt = cleanLines[1];

  spd_eeprom_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclF      (sclFilt),
    .sdaF      (sdaFilt),
    .strapAddr (strapAddr),
    .rxByte    (rxByte),
    .strobe    (strobe),
    .state     (ctrlState),
    .ackDrive  (ackDrive),
    .sendPhase (sendPhase),
    .busy      (busy)
  );

  spd_eeprom_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .sdaBit (sdaFilt),
    .wpIn   (wpIn),
    .rxByte (rxByte),
    .ptr    (ptr),
    .txMsb  (txMsb)
  );

  assign sdaOe = ackDrive || (sendPhase && !txMsb);
endmodule

// File: rtl/spd_eeprom_checker.sv
`timescale 1ns/1ps
module spd_eeprom_checker
  import spd_eeprom_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclF,
  input logic              sdaF,
  input logic              sdaOe,
  input ctrlState_t        state,
  input logic              busy,
  input logic              loadTx,
  input logic              loadPtr,
  input logic [ADDR_W-1:0] ptr,
  input logic [7:0]        rxByte
);
  a_r10_sda_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF)) |-> $stable(sdaOe));

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV_ACK && $past(state) == ST_DEV) |-> !$past(busy));

  a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(sclF) && $past(sdaF) && !$past(sdaF, 2)));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    loadTx |=> (ptr == $past(ptr) + 1'b1));

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    loadPtr |=> (ptr == $past(rxByte)));
endmodule

bind spd_eeprom_slave spd_eeprom_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclF    (sclFilt),
  .sdaF    (sdaFilt),
  .sdaOe   (sdaOe),
  .state   (ctrlState),
  .busy    (busy),
  .loadTx  (strobe.loadTx),
  .loadPtr (strobe.loadPtr),
  .ptr     (ptr),
  .rxByte  (rxByte)
);

// File: tb/spd_eeprom_slave_tb.sv
`timescale 1ns/1ps
module spd_eeprom_slave_tb;
  localparam int FL = 4;
  localparam int WC = 2000;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEVA = {4'b1010, STRAP};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic wp = 1'b0;
  logic glitchMode = 1'b0;
  logic sdaOe;
  wire  sdaBus = mSda & ~sdaOe;

  int errors = 0;
  int checks = 0;
  int r10Viol = 0;
  logic [7:0] upper [128];

  always #2 clk = ~clk;

  spd_eeprom_slave #(.FILT_LEN(FL), .WRITE_CYCLES(WC)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (mScl),
    .sdaIn     (sdaBus),
    .sdaOe     (sdaOe),
    .strapAddr (STRAP),
    .wpIn      (wp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] romByte(input int i);
    int s;
    if (i == 63) begin
      s = 0;
      for (int k = 0; k < 63; k++) s += (5 * k + 17) % 256;
      return 8'(s % 256);
    end
    return 8'((5 * i + 17) % 256);
  endfunction

  function automatic logic [7:0] expect_at(input int a);
    return (a < 128) ? romByte(a) : upper[a - 128];
  endfunction

  task automatic busStart();
    mSda = 1'b1; wt(Q);
    mScl = 1'b1; wt(Q);
    mSda = 1'b0; wt(Q);
    mScl = 1'b0; wt(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; wt(Q);
    mScl = 1'b1; wt(Q);
    mSda = 1'b1; wt(Q);
  endtask

  task automatic writeBit(input logic b);
    mSda = b;
    if (glitchMode) begin
      wt(4); mScl = 1'b1; wt(2); mScl = 1'b0; wt(4);
    end else begin
      wt(Q);
    end
    mScl = 1'b1; wt(2 * Q);
    mScl = 1'b0; wt(Q);
  endtask

  task automatic readBit(output logic b);
    logic early;
    mSda = 1'b1; wt(Q);
    mScl = 1'b1; wt(1);
    early = sdaBus;
    wt(Q - 1);
    b = sdaBus;
    if (early !== b) r10Viol++;
    wt(Q);
    mScl = 1'b0; wt(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic bitv;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(bitv);
    acked = (bitv == 1'b0);
  endtask

  task automatic readByte(output logic [7:0] v, input logic ackIt);
    logic bitv;
    for (int i = 7; i >= 0; i--) begin
      readBit(bitv);
      v[i] = bitv;
    end
    writeBit(ackIt ? 1'b0 : 1'b1);
  endtask

  task automatic writeBytes(input logic [7:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                            input int n, input string req);
    logic a;
    busStart();
    writeByte({DEVA, 1'b0}, a); chk({req, " device ack"}, a, 1'b1);
    writeByte(addr, a);         chk({req, " word ack"}, a, 1'b1);
    writeByte(d0, a);           chk({req, " data ack"}, a, 1'b1);
    if (!wp && addr >= 8'd128) upper[addr - 128] = d0;
    if (n > 1) begin
      writeByte(d1, a);         chk({req, " data2 ack"}, a, 1'b1);
      if (!wp && 8'(addr + 1) >= 8'd128) upper[8'(addr + 1) - 128] = d1;
    end
    busStop();
    wt(WC + 100);
  endtask

  task automatic readAt(input logic [7:0] addr, output logic [7:0] v, input string req);
    logic a;
    busStart();
    writeByte({DEVA, 1'b0}, a); chk({req, " device ack"}, a, 1'b1);
    glitchMode = (req == "R8");
    writeByte(addr, a);
    glitchMode = 1'b0;
    chk({req, " word ack"}, a, 1'b1);
    busStart();
    writeByte({DEVA, 1'b1}, a); chk({req, " read ack"}, a, 1'b1);
    readByte(v, 1'b0);
    busStop();
  endtask

  task automatic curRead(output logic [7:0] v, input string req);
    logic a;
    busStart();
    writeByte({DEVA, 1'b1}, a); chk({req, " read ack"}, a, 1'b1);
    readByte(v, 1'b0);
    busStop();
  endtask

  task automatic probe(input logic [6:0] dev, output logic acked);
    busStart();
    writeByte({dev, 1'b0}, acked);
    busStop();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R9 sdaOe after reset", sdaOe, 1'b0);
    curRead(v, "R9");
    chk("R9 pointer zero read", v, romByte(0));
    readAt(8'h85, v, "R9");
    chk("R9 upper reset value", v, 8'hFF);
  endtask

  task automatic t_address();
    logic a;
    probe({4'b1010, 3'b010}, a);
    chk("R1 wrong strap nack", a, 1'b0);
    probe({4'b0110, STRAP}, a);
    chk("R1 wrong type nack", a, 1'b0);
    probe(DEVA, a);
    chk("R1 own address ack", a, 1'b1);
  endtask

  task automatic t_rom();
    logic [7:0] v;
    readAt(8'd62, v, "R6");
    chk("R6 byte 62", v, romByte(62));
    readAt(8'd63, v, "R6");
    chk("R6 checksum byte 63", v, romByte(63));
    readAt(8'd127, v, "R6");
    chk("R6 byte 127", v, romByte(127));
  endtask

  task automatic t_write();
    logic [7:0] v;
    writeBytes(8'h80, 8'hA5, 8'h00, 1, "R2");
    readAt(8'h80, v, "R2");
    chk("R2 readback 0x80", v, 8'hA5);
    writeBytes(8'hC4, 8'h5A, 8'h3C, 2, "R2");
    readAt(8'hC5, v, "R2");
    chk("R2 sequential write 0xC5", v, 8'h3C);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    writeBytes(8'h10, 8'h00, 8'h00, 1, "R3");
    readAt(8'h10, v, "R3");
    chk("R3 locked byte unchanged", v, romByte(16));
  endtask

  task automatic t_protect();
    logic [7:0] v;
    wp = 1'b1;
    writeBytes(8'h90, 8'h3C, 8'h00, 1, "R4");
    readAt(8'h90, v, "R4");
    chk("R4 protected byte unchanged", v, 8'hFF);
    wp = 1'b0;
  endtask

  task automatic t_busy();
    logic a;
    busStart();
    writeByte({DEVA, 1'b0}, a);
    writeByte(8'hA0, a);
    writeByte(8'h77, a);
    upper[8'hA0 - 128] = 8'h77;
    busStop();
    probe(DEVA, a);
    chk("R7 nack during write cycle", a, 1'b0);
    wt(WC + 100);
    probe(DEVA, a);
    chk("R7 ack after write cycle", a, 1'b1);
  endtask

  task automatic t_sequence();
    logic [7:0] v;
    logic a;
    writeBytes(8'hFE, 8'h12, 8'h34, 2, "R5");
    busStart();
    writeByte({DEVA, 1'b0}, a);
    writeByte(8'hFE, a);
    busStart();
    writeByte({DEVA, 1'b1}, a);
    chk("R5 read ack", a, 1'b1);
    readByte(v, 1'b1); chk("R5 byte 0xFE", v, 8'h12);
    readByte(v, 1'b1); chk("R5 byte 0xFF", v, 8'h34);
    readByte(v, 1'b0); chk("R5 wrap to 0", v, romByte(0));
    busStop();
    curRead(v, "R5");
    chk("R5 current read continues", v, romByte(1));
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    readAt(8'h40, v, "R8");
    chk("R8 glitched address read", v, romByte(64));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) upper[i] = 8'hFF;
    wt(10);
    rstN = 1'b1;
    wt(20);
    t_reset();
    t_address();
    t_rom();
    t_write();
    t_locked();
    t_protect();
    t_busy();
    t_sequence();
    t_glitch();
    chk("R10 slave sda stable while scl high", r10Viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule